// File: doc/BRIEF.md
# Data EEPROM Range Read Sequencer

This block drives a command engine that talks to a target device. It reads a run of consecutive bytes from the target's data EEPROM. A single start pulse gives it a start address and a byte count. For each address it sends a fixed script of core-instruction transactions, and the address is placed inside one of those instructions. It then sends one shift-out transaction and waits for the engine to return the byte.

Each returned byte leaves on an output stream together with the address it came from. The block then moves to the next address, which wraps modulo 2^ADDR_W. Toward the engine it uses a valid/ready request carrying a 4-bit command code and a 16-bit payload. The byte comes back as a one-cycle response strobe. A busy flag covers the whole range, and a done pulse marks its end.

Top module: `eerd_seq`

## Requirements
- R1: After reset, busy_o, done_o, cmd_valid_o and out_valid_o are all low.
- R2: A start_i pulse is taken only while idle with cnt_i non-zero. A start_i pulse while busy, or with cnt_i equal to 0, has no effect on outputs or on the running sequence.
- R3: The first byte of a range opens with two requests of code 0x0 carrying payloads 0x9EA6 and then 0x9CA6. These clear the program-memory select bit and then the configuration-space select bit.
- R4: For every byte, the block issues code-0x0 requests with these payloads, in this order: {0x0E, addr}, 0x6EA9, 0x80A6, 0x50A8, 0x6EF5, 0x0000. It then issues one request with code 0x2 and payload 0x0000, which is the shift-out.
- R5: Every byte after the first restarts at the {0x0E, addr} request and does not repeat the 0x9EA6 and 0x9CA6 requests.
- R6: Bytes are read from consecutive addresses starting at addr_i, wrapping modulo 2^ADDR_W. cnt_i ranges from 1 to 2^ADDR_W, and exactly cnt_i bytes are delivered.
- R7: A request holds cmd_valid_o, cmd_code_o and cmd_payload_o stable until cmd_ready_i is high at a clock edge.
- R8: After a shift-out request is accepted, the block issues nothing until rsp_valid_i arrives. The byte on rsp_data_i then appears on out_data_o, with its address on out_addr_o. out_valid_o and both fields hold until out_ready_i, and no request is issued during that wait.
- R9: busy_o rises in the cycle after an accepted start. It falls in the cycle after the last byte is accepted, and done_o is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| addr_i | input | ADDR_W | First EEPROM address |
| cnt_i | input | ADDR_W+1 | Byte count, 1 to 2^ADDR_W |
| cmd_valid_o | output | 1 | Engine request valid |
| cmd_ready_i | input | 1 | Engine request accepted |
| cmd_code_o | output | 4 | Engine command code |
| cmd_payload_o | output | 16 | Engine command payload |
| rsp_valid_i | input | 1 | Shift-out byte returned |
| rsp_data_i | input | 8 | Returned byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_addr_o | output | ADDR_W | Address of the output byte |
| out_data_o | output | 8 | Output byte |
| busy_o | output | 1 | Range in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default ADDR_W of 8. This keeps a full 256-byte range, and a range that wraps past address 0xFF, short enough to run in full. With those values it reaches the count boundaries of 1 and 256 and the wrap from 0xFF to 0x00. It also reaches back-pressure on both the engine side and the output side, and start pulses that are ignored.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  localparam int CODE_W    = 4;
  localparam int PAY_W     = 16;
  localparam int STEP_W    = 4;
  localparam int STEP_LOOP = 2;  // re-entry point for bytes after the first
  localparam int STEP_LAST = 8;  // shift-out step

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_OUT
  } st_e;
endpackage

// File: rtl/eerd_script.sv
module eerd_script
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CODE_W-1:0] code_o,
  output logic [PAY_W-1:0]  pay_o
);
  always_comb begin
    code_o = '0;
    pay_o  = '0;
    unique case (step_i)
      4'd0: pay_o = 16'h9EA6;
      4'd1: pay_o = 16'h9CA6;
      4'd2: pay_o = {8'h0E, 8'(addr_i)};
      4'd3: pay_o = 16'h6EA9;
      4'd4: pay_o = 16'h80A6;
      4'd5: pay_o = 16'h50A8;
      4'd6: pay_o = 16'h6EF5;
      4'd7: pay_o = 16'h0000;
      4'd8: code_o = 4'h2;
      default: ;
    endcase
  end
endmodule

// File: rtl/eerd_range.sv
module eerd_range #(
  parameter int ADDR_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= cnt_i;
    end else if (adv_i) begin
      addr_q <= addr_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == CNT_W'(1));

  a_r6_no_adv_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> rem_q > CNT_W'(1));
endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic [PAY_W-1:0]  cmd_payload_o,
  input  logic              rsp_valid_i,
  input  logic [7:0]        rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [7:0]        out_data_o,
  output logic              busy_o,
  output logic              done_o
);
  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        data_q;
  logic              done_q;
  logic              load, adv, last;
  logic [ADDR_W-1:0] cur_addr;

  assign load = (st_q == ST_IDLE) && start_i && (cnt_i != '0);
  assign adv  = (st_q == ST_OUT) && out_ready_i && !last;

  eerd_range #(.ADDR_W(ADDR_W)) u_range (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .addr_i (addr_i),
    .cnt_i  (cnt_i),
    .addr_o (cur_addr),
    .last_o (last)
  );

  eerd_script #(.ADDR_W(ADDR_W)) u_script (
    .step_i (step_q),
    .addr_i (cur_addr),
    .code_o (cmd_code_o),
    .pay_o  (cmd_payload_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (load) begin
          step_q <= '0;
          st_q   <= ST_CMD;
        end
        ST_CMD: if (cmd_ready_i) begin
          if (step_q == STEP_W'(STEP_LAST)) st_q <= ST_WAIT;
          else step_q <= step_q + 1'b1;
        end
        ST_WAIT: if (rsp_valid_i) begin
          data_q <= rsp_data_i;
          st_q   <= ST_OUT;
        end
        ST_OUT: if (out_ready_i) begin
          if (last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            step_q <= STEP_W'(STEP_LOOP);
            st_q   <= ST_CMD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == ST_CMD);
  assign out_valid_o = (st_q == ST_OUT);
  assign out_addr_o  = cur_addr;
  assign out_data_o  = data_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  a_r7_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_payload_o));
  a_r8_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_addr_o));
  a_r8_no_cmd_while_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && out_valid_o));
  a_r8_shift_then_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && cmd_code_o == 4'h2 |=> !cmd_valid_o && !out_valid_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o && out_ready_i));
endmodule

// File: tb/tb_eerd_seq.sv
module tb_eerd_seq;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = ADDR_W + 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [CNT_W-1:0]  cnt_i = '0;
  logic              cmd_valid_o, cmd_ready_i = 1'b0;
  logic [3:0]        cmd_code_o;
  logic [15:0]       cmd_payload_o;
  logic              rsp_valid_i = 1'b0;
  logic [7:0]        rsp_data_i = '0;
  logic              out_valid_o, out_ready_i = 1'b0;
  logic [ADDR_W-1:0] out_addr_o;
  logic [7:0]        out_data_o;
  logic              busy_o, done_o;

  eerd_seq #(.ADDR_W(ADDR_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  int tests = 0, fails = 0, cycles = 0;
  int cmd_pct = 100, out_pct = 100;
  bit running = 0;

  logic [19:0] exp_cmd[$];
  logic [15:0] exp_out[$];  // {addr, data}
  bit  exp_busy = 0, exp_done = 0;
  int  rem_exp = 0;
  bit  eng_go = 0, eng_wait = 0;
  int  eng_dly = 0;
  logic [7:0] eng_addr = '0;

  function automatic logic [7:0] mem(logic [7:0] a);
    return (a * 8'd37) ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model and comparison, every falling edge
  always @(negedge clk_i) begin
    bit last_fire;
    if (running) begin
      cycles++;
      last_fire = 0;
      chk(busy_o == exp_busy, "R9", "busy", busy_o, exp_busy);
      chk(done_o == exp_done, "R9", "done", done_o, exp_done);
      if (cmd_valid_o) begin
        if (exp_cmd.size() == 0)
          chk(0, "R8", "unexpected request", {cmd_code_o, cmd_payload_o}, 0);
        else if (cmd_ready_i) begin
          logic [19:0] e;
          e = exp_cmd.pop_front();
          chk({cmd_code_o, cmd_payload_o} == e, "R4", "request", {cmd_code_o, cmd_payload_o}, e);
          if (cmd_code_o == 4'h0 && cmd_payload_o[15:8] == 8'h0E) eng_addr = cmd_payload_o[7:0];
          if (cmd_code_o == 4'h2) eng_go = 1;
        end
      end
      if (out_valid_o && out_ready_i) begin
        if (exp_out.size() == 0)
          chk(0, "R6", "unexpected byte", {out_addr_o, out_data_o}, 0);
        else begin
          logic [15:0] e;
          e = exp_out.pop_front();
          chk({out_addr_o, out_data_o} == e, "R8", "byte", {out_addr_o, out_data_o}, e);
          rem_exp--;
          if (rem_exp == 0) begin
            last_fire = 1;
            exp_busy  = 0;
          end
        end
      end
      exp_done = last_fire;
      if (start_i && !exp_busy && cnt_i != '0) begin
        exp_busy = 1;
        rem_exp  = int'(cnt_i);
        exp_cmd.push_back({4'h0, 16'h9EA6});  // R3
        exp_cmd.push_back({4'h0, 16'h9CA6});
        for (int i = 0; i < int'(cnt_i); i++) begin
          logic [7:0] a;
          a = addr_i + 8'(i);                 // R6 wrap
          exp_cmd.push_back({4'h0, 8'h0E, a}); // R5 loop start
          exp_cmd.push_back({4'h0, 16'h6EA9});
          exp_cmd.push_back({4'h0, 16'h80A6});
          exp_cmd.push_back({4'h0, 16'h50A8});
          exp_cmd.push_back({4'h0, 16'h6EF5});
          exp_cmd.push_back({4'h0, 16'h0000});
          exp_cmd.push_back({4'h2, 16'h0000});
          exp_out.push_back({a, mem(a)});
        end
      end
    end
  end

  // engine and sink model, driven after the rising edge
  always @(posedge clk_i) begin
    #2;
    cmd_ready_i = ($urandom % 100) < cmd_pct;
    out_ready_i = ($urandom % 100) < out_pct;
    rsp_valid_i = 1'b0;
    if (eng_go) begin
      eng_go   = 0;
      eng_wait = 1;
      eng_dly  = $urandom % 4;
    end else if (eng_wait) begin
      if (eng_dly == 0) begin
        rsp_valid_i = 1'b1;
        rsp_data_i  = mem(eng_addr);
        eng_wait    = 0;
      end else eng_dly--;
    end
  end

  task automatic pulse(logic [7:0] a, int n);
    @(posedge clk_i); #2;
    start_i = 1'b1; addr_i = a; cnt_i = CNT_W'(n);
    @(posedge clk_i); #2;
    start_i = 1'b0; addr_i = 8'hA5; cnt_i = CNT_W'(7);
  endtask

  task automatic finish_run();
    repeat (2) @(posedge clk_i);
    while ((exp_busy || exp_out.size() != 0) && cycles < 150000) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    chk(exp_cmd.size() == 0, "R6", "requests left", exp_cmd.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !cmd_valid_o && !out_valid_o, "R1", "reset outputs",
        {busy_o, done_o, cmd_valid_o, out_valid_o}, 0);
    running = 1;

    cmd_pct = 100; out_pct = 100;
    pulse(8'h10, 3); finish_run();               // R3 R4 R5
    cmd_pct = 50; out_pct = 40;
    pulse(8'hFE, 4); finish_run();               // R6 wrap, R7 R8 stalls
    pulse(8'h55, 1); finish_run();               // R6 single
    pulse(8'h00, 0); repeat (4) @(posedge clk_i); // R2 count zero
    @(negedge clk_i);
    chk(!busy_o && !cmd_valid_o, "R2", "count zero ignored", busy_o, 0);
    cmd_pct = 70; out_pct = 60;
    pulse(8'h30, 3);
    repeat (10) @(posedge clk_i);
    pulse(8'h90, 5);                             // R2 start while busy
    finish_run();
    cmd_pct = 90; out_pct = 80;
    pulse(8'h80, 256); finish_run();             // R6 full range

    if (cycles >= 150000) chk(0, "R9", "watchdog", cycles, 0);
    running = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule